// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is a register-mapped master for the two-wire PHY management bus. Software programs a 32-bit command word holding a launch bit, a frame-type bit, a 2-bit opcode, a 5-bit PHY address, a 5-bit register (or device) address and 16 bits of write data. The block then clocks out one complete management frame on MDC/MDIO and clears the launch bit once the last bit has gone out. For read frames it releases the data line, samples the PHY's answer and posts it in a second register next to an idle flag. That idle flag also means the read data is valid.

The second register also holds the timing setup: an MDC half-period in system clocks, an edge-select bit and a read-sample delay. These three values are captured when a frame launches, so later changes only apply to the next frame. A Clause 45 access is made of two launches from software, an address frame and then a data frame. The master only serializes one frame per launch and keeps no state between frames.

Sequencing uses five named states. ST_IDLE moves to ST_PRE on a launch. ST_PRE moves to ST_HEAD after the last preamble bit window. ST_HEAD moves to ST_TURN after the 14 header bits. ST_TURN moves to ST_DATA after the two turnaround bits. ST_DATA returns to ST_IDLE after the sixteenth data bit.

Top module: `mdio_master`

## Requirements
- R1: After reset, the command register reads 0. The setup/status register reads half-period = DEF_THR, edge 0, delay 0, idle flag (bit 16) = 1 and read data 0. MDC is low, the MDIO enable is low and the MDIO output is 1.
- R2: The command register is at byte offset 0x0 and has this layout: bit 31 launch, bits 30:29 spare storage, bit 28 frame type (1 = Clause 22, 0 = Clause 45), bits 27:26 opcode, bits 25:21 PHY address, bits 20:16 register/device address, bits 15:0 write data. Bits 30:0 read back as written.
- R3: A write with bit 31 = 1 while idle launches one frame. Bit 31 then reads 1 and the idle flag reads 0 until the frame ends, and both return to their idle values in the cycle after the last bit window.
- R4: A command write with bit 31 = 0 while idle stores the fields and starts no frame. MDC stays low and the idle flag stays 1.
- R5: A command write while a frame is running is ignored. The stored fields are unchanged and the running frame is not altered.
- R6: Each frame sends, MSB first, 32 ones, then the start field {0, type bit} (01 for Clause 22, 00 for Clause 45), the opcode, the PHY address and the register/device address.
- R7: Frames whose opcode bit 1 is 0 (write, address) keep MDIO driven for all 64 bits and send turnaround 1 then 0, followed by the 16 write-data bits MSB first.
- R8: Frames whose opcode bit 1 is 1 (reads) release MDIO for the last 18 bits and shift in 16 bits MSB first. The result appears in bits 15:0 of the setup/status register at offset 0x4. Non-read frames leave those bits unchanged.
- R9: Each bit window lasts 2H system clocks, where H is the half-period field (bits 31:24 at 0x4), and H = 0 is treated as 1. With edge bit 23 = 0, MDC is low for the first H clocks and high for the next H, and MDIO changes at the window start. With edge = 1, MDC is high first and then low.
- R10: A read bit is sampled at clock min(H + D, 2H − 1) of its window, counting from 0 at the window start, where D is the delay field (bits 22:20 at 0x4).
- R11: Bits 31:20 of offset 0x4 are writable at any time and read back as written. The values used by a frame are those held when it launched.
- R12: Between frames MDC is low, MDIO is released and the MDIO output is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write qualifier for the access |
| bus_addr | input | ADDR_W | Byte address (0x0 command, 0x4 setup/status) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
A behavioural model predicts MDC, the MDIO enable and the MDIO value for every clock. It is driven with Clause 22 writes and reads and with a Clause 45 address-then-read pair. These use half-periods of 2, 3 and 0, both edge settings and sample delays of 0, 2 and 7. Together they separate the frame-type encoding, the opcode-driven release and the half-period clamp. The bench's PHY drives the inverse of each answer bit on every clock except the predicted sample clock. A sample point off by even one clock therefore corrupts the read word. Command writes during a frame, setup writes during a frame and a command write without the launch bit show that the fields are ignored, that the setup is captured at launch and that a store does not start a frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PHY_W = 5;
    localparam int REG_W = 5;
    localparam int OP_W  = 2;
    localparam int DAT_W = 16;
    localparam int THR_W = 8;
    localparam int LAT_W = 3;

    // header = start field + opcode + PHY address + register address
    localparam int HDR_BITS = 2 + OP_W + PHY_W + REG_W;
    localparam int TA_BITS  = 2;

    // command register bits 30:0 (bit 31 is the launch bit, reported from state)
    typedef struct packed {
        logic [1:0]       spare;
        logic             c22;
        logic [OP_W-1:0]  op;
        logic [PHY_W-1:0] phy;
        logic [REG_W-1:0] regad;
        logic [DAT_W-1:0] data;
    } mdio_ctrl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HEAD,
        ST_TURN,
        ST_DATA
    } mdio_state_t;

endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int               ADDR_W  = 4,
    parameter logic [THR_W-1:0] DEF_THR = 8'd10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              busy,
    input  logic [DAT_W-1:0]  rd_data,
    output logic              launch,
    output logic [THR_W-1:0]  cfg_thr,
    output logic              cfg_edge,
    output logic [LAT_W-1:0]  cfg_lat
);

    localparam logic [ADDR_W-1:0] CMD_A = '0;
    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(4);

    mdio_ctrl_t ctrl_q;
    logic       wr_cmd;
    logic       wr_set;

    assign wr_cmd = bus_en && bus_we && (bus_addr == CMD_A);
    assign wr_set = bus_en && bus_we && (bus_addr == SET_A);
    assign launch = wr_cmd && !busy && bus_wdata[31];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            cfg_thr  <= DEF_THR;
            cfg_edge <= 1'b0;
            cfg_lat  <= '0;
        end else begin
            if (wr_cmd && !busy) begin
                ctrl_q <= mdio_ctrl_t'(bus_wdata[30:0]);
            end
            if (wr_set) begin
                cfg_thr  <= bus_wdata[31:24];
                cfg_edge <= bus_wdata[23];
                cfg_lat  <= bus_wdata[22:20];
            end
        end
    end

    always_comb begin
        if (bus_addr == CMD_A) begin
            bus_rdata = {busy, ctrl_q};
        end else if (bus_addr == SET_A) begin
            bus_rdata = {cfg_thr, cfg_edge, cfg_lat, 3'b000, !busy, rd_data};
        end else begin
            bus_rdata = '0;
        end
    end

    AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_cmd) |=> $stable(ctrl_q)); // R5

endmodule

// File: rtl/mdio_timer.sv
module mdio_timer
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             run,
    input  logic [THR_W-1:0] cfg_thr,
    input  logic             cfg_edge,
    input  logic [LAT_W-1:0] cfg_lat,
    output logic             mdc,
    output logic             win_end,
    output logic             samp_stb
);

    localparam int PH_W = THR_W + 1;

    logic [THR_W-1:0] half_q;
    logic             edge_q;
    logic [LAT_W-1:0] lat_q;
    logic [PH_W-1:0]  ph_q;
    logic [PH_W-1:0]  half_x;
    logic [PH_W-1:0]  last_ph;
    logic [PH_W-1:0]  samp_raw;
    logic [PH_W-1:0]  samp_pt;

    assign half_x   = {1'b0, half_q};
    assign last_ph  = {half_q, 1'b0} - PH_W'(1);
    assign samp_raw = half_x + PH_W'(lat_q);
    assign samp_pt  = (samp_raw > last_ph) ? last_ph : samp_raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= THR_W'(1);
            edge_q <= 1'b0;
            lat_q  <= '0;
            ph_q   <= '0;
        end else if (launch) begin
            half_q <= (cfg_thr == '0) ? THR_W'(1) : cfg_thr;
            edge_q <= cfg_edge;
            lat_q  <= cfg_lat;
            ph_q   <= '0;
        end else if (run) begin
            ph_q <= (ph_q == last_ph) ? '0 : ph_q + PH_W'(1);
        end else begin
            ph_q <= '0;
        end
    end

    always_comb begin
        win_end  = run && (ph_q == last_ph);
        samp_stb = run && (ph_q == samp_pt);
        if (!run) begin
            mdc = 1'b0;
        end else if (edge_q) begin
            mdc = ph_q < half_x;
        end else begin
            mdc = ph_q >= half_x;
        end
    end

    AST_PHASE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (ph_q <= last_ph)); // R9

    AST_HALF_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (half_q != '0)); // R9

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
#(
    parameter int PRE_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             cmd_c22,
    input  logic [OP_W-1:0]  cmd_op,
    input  logic [PHY_W-1:0] cmd_phy,
    input  logic [REG_W-1:0] cmd_reg,
    input  logic [DAT_W-1:0] cmd_data,
    input  logic             win_end,
    input  logic             samp_stb,
    input  logic             mdio_i,
    output logic             busy,
    output logic             mdio_o,
    output logic             mdio_oe,
    output logic [DAT_W-1:0] rd_data
);

    localparam int FRAME_BITS = PRE_BITS + HDR_BITS + TA_BITS + DAT_W;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    localparam logic [CNT_W-1:0] PRE_END  = CNT_W'(PRE_BITS - 1);
    localparam logic [CNT_W-1:0] HEAD_END = CNT_W'(PRE_BITS + HDR_BITS - 1);
    localparam logic [CNT_W-1:0] TURN_END = CNT_W'(PRE_BITS + HDR_BITS + TA_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    mdio_state_t           state_q;
    mdio_state_t           state_d;
    logic [CNT_W-1:0]      cnt_q;
    logic [FRAME_BITS-1:0] shreg_q;
    logic                  rd_q;
    logic [DAT_W-1:0]      acc_q;
    logic [DAT_W-1:0]      acc_next;
    logic [DAT_W-1:0]      rd_data_q;

    assign acc_next = {acc_q[DAT_W-2:0], mdio_i};
    assign rd_data  = rd_data_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch)                         state_d = ST_PRE;
            ST_PRE:  if (win_end && cnt_q == PRE_END)    state_d = ST_HEAD;
            ST_HEAD: if (win_end && cnt_q == HEAD_END)   state_d = ST_TURN;
            ST_TURN: if (win_end && cnt_q == TURN_END)   state_d = ST_DATA;
            ST_DATA: if (win_end && cnt_q == LAST_BIT)   state_d = ST_IDLE;
            default:                                     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // frame shift register, bit counter and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            shreg_q   <= '1;
            rd_q      <= 1'b0;
            acc_q     <= '0;
            rd_data_q <= '0;
        end else if (launch && state_q == ST_IDLE) begin
            cnt_q   <= '0;
            shreg_q <= {{PRE_BITS{1'b1}}, 1'b0, cmd_c22, cmd_op, cmd_phy, cmd_reg,
                        2'b10, cmd_data};
            rd_q    <= cmd_op[1];
            acc_q   <= '0;
        end else if (state_q != ST_IDLE) begin
            if (samp_stb && rd_q && state_q == ST_DATA) begin
                acc_q <= acc_next;
            end
            if (win_end) begin
                shreg_q <= {shreg_q[FRAME_BITS-2:0], 1'b1};
                cnt_q   <= cnt_q + CNT_W'(1);
                if (state_q == ST_DATA && cnt_q == LAST_BIT && rd_q) begin
                    rd_data_q <= samp_stb ? acc_next : acc_q;
                end
            end
        end
    end

    // pin and status outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        mdio_oe = busy && !(rd_q && (state_q == ST_TURN || state_q == ST_DATA));
        mdio_o  = mdio_oe ? shreg_q[FRAME_BITS-1] : 1'b1;
    end

    AST_LAUNCH_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (state_q == ST_IDLE)); // R5

    AST_DATA_AFTER_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (cnt_q > TURN_END)); // R8

    AST_END_ON_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(win_end)); // R3

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int               ADDR_W   = 4,
    parameter int               PRE_BITS = 32,
    parameter logic [THR_W-1:0] DEF_THR  = 8'd10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    logic             launch;
    logic             busy;
    logic             win_end;
    logic             samp_stb;
    logic [THR_W-1:0] cfg_thr;
    logic             cfg_edge;
    logic [LAT_W-1:0] cfg_lat;
    logic [DAT_W-1:0] rd_data;

    mdio_regs #(
        .ADDR_W  (ADDR_W),
        .DEF_THR (DEF_THR)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .rd_data   (rd_data),
        .launch    (launch),
        .cfg_thr   (cfg_thr),
        .cfg_edge  (cfg_edge),
        .cfg_lat   (cfg_lat)
    );

    mdio_timer timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .run      (busy),
        .cfg_thr  (cfg_thr),
        .cfg_edge (cfg_edge),
        .cfg_lat  (cfg_lat),
        .mdc      (mdc_o),
        .win_end  (win_end),
        .samp_stb (samp_stb)
    );

    mdio_frame_fsm #(
        .PRE_BITS (PRE_BITS)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .cmd_c22  (bus_wdata[28]),
        .cmd_op   (bus_wdata[27:26]),
        .cmd_phy  (bus_wdata[25:21]),
        .cmd_reg  (bus_wdata[20:16]),
        .cmd_data (bus_wdata[15:0]),
        .win_end  (win_end),
        .samp_stb (samp_stb),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_data  (rd_data)
    );

    AST_QUIET_BETWEEN_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc_o && !mdio_oe && mdio_o)); // R12

endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb_top;

    localparam int         ADDR_W  = 4;
    localparam logic [7:0] DEF_THR = 8'd10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_en = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              mdc_o;
    logic              mdio_o;
    logic              mdio_oe;
    logic              mdio_i = 1'b1;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    mdio_master #(.ADDR_W(ADDR_W), .PRE_BITS(32), .DEF_THR(DEF_THR)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // ---------------- behavioural reference model ----------------
    bit          bitq[$];
    bit          oeq[$];
    int          m_busy = 0;
    int          m_ph = 0;
    int          m_half = 1;
    int          m_edge = 0;
    int          m_lat = 0;
    int          m_read = 0;
    int          c_thr = DEF_THR;
    int          c_edge = 0;
    int          c_lat = 0;
    logic [15:0] resp = 16'h0;
    logic [15:0] m_rdata = 16'h0;

    function automatic void push_field(logic [15:0] v, int n, bit drv);
        for (int i = n - 1; i >= 0; i--) begin
            bitq.push_back(v[i]);
            oeq.push_back(drv);
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            bitq.delete(); oeq.delete();
            m_busy = 0; m_ph = 0; m_rdata = 16'h0;
            c_thr = DEF_THR; c_edge = 0; c_lat = 0;
            mdio_i <= 1'b1;
        end else begin
            if (m_busy != 0) begin
                if (m_ph == 2 * m_half - 1) begin
                    void'(bitq.pop_front()); void'(oeq.pop_front());
                    m_ph = 0;
                    if (bitq.size() == 0) begin
                        m_busy = 0;
                        if (m_read != 0) m_rdata = resp;
                    end
                end else begin
                    m_ph++;
                end
            end else if (bus_en && bus_we && bus_addr == 0 && bus_wdata[31]) begin
                m_read = bus_wdata[27];
                push_field(16'hFFFF, 16, 1'b1);
                push_field(16'hFFFF, 16, 1'b1);
                push_field({15'd0, bus_wdata[28]}, 2, 1'b1);
                push_field({14'd0, bus_wdata[27:26]}, 2, 1'b1);
                push_field({11'd0, bus_wdata[25:21]}, 5, 1'b1);
                push_field({11'd0, bus_wdata[20:16]}, 5, 1'b1);
                push_field(16'h0002, 2, m_read == 0);
                push_field(bus_wdata[15:0], 16, m_read == 0);
                m_busy = 1; m_ph = 0;
                m_half = (c_thr == 0) ? 1 : c_thr;
                m_edge = c_edge; m_lat = c_lat;
            end
            if (bus_en && bus_we && bus_addr == 4) begin
                c_thr = bus_wdata[31:24]; c_edge = bus_wdata[23]; c_lat = bus_wdata[22:20];
            end
            begin
                int k;
                int sp;
                k = 64 - bitq.size();
                sp = (m_half + m_lat > 2 * m_half - 1) ? 2 * m_half - 1 : m_half + m_lat;
                if (m_busy != 0 && m_read != 0 && k >= 48)
                    mdio_i <= (m_ph == sp) ? resp[63 - k] : ~resp[63 - k];
                else
                    mdio_i <= 1'b1;
            end
        end
    end

    // per-clock comparison of the pins against the model
    always @(negedge clk) begin
        if (rst_n) begin
            logic e_mdc, e_oe, e_o;
            e_mdc = (m_busy != 0) && ((m_edge != 0) ? (m_ph < m_half) : (m_ph >= m_half));
            e_oe  = (m_busy != 0) && oeq[0];
            e_o   = e_oe ? bitq[0] : 1'b1;
            checks++;
            if ({mdc_o, mdio_oe, mdio_o} !== {e_mdc, e_oe, e_o}) begin
                failures++;
                $display("FAIL R6 R7 R9 R12 pins {mdc,oe,o} actual=%b%b%b expected=%b%b%b t=%0t",
                         mdc_o, mdio_oe, mdio_o, e_mdc, e_oe, e_o, $time);
            end
        end
    end

    // ---------------- tasks ----------------
    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int i = 0; i < 20000; i++) begin
            bus_read(4, d);
            if (d[16]) return;
        end
        check("R3 idle timeout", 32'h0, 32'h1);
    endtask

    function automatic logic [31:0] mk(bit st, bit c22, logic [1:0] op,
                                       logic [4:0] phy, logic [4:0] rg, logic [15:0] dat);
        return {st, 2'b00, c22, op, phy, rg, dat};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_read(0, d); check("R1 cmd reg", d, 32'h0);
        bus_read(4, d); check("R1 setup reg", d, {DEF_THR, 1'b0, 3'd0, 3'd0, 1'b1, 16'h0});
        check("R1 pins", {29'd0, mdc_o, mdio_oe, mdio_o}, 32'h1);

        // R11: setup write and readback
        bus_write(4, 32'h0200_0000);
        bus_read(4, d); check("R11 setup readback", d, 32'h0201_0000);

        // R3 R6 R7: Clause 22 write
        bus_write(0, mk(1, 1, 2'b01, 5'd5, 5'h11, 16'hA5C3));
        repeat (3) @(negedge clk);
        bus_read(0, d); check("R3 launch bit set while running", {31'd0, d[31]}, 32'h1);
        bus_read(4, d); check("R3 idle flag low while running", {31'd0, d[16]}, 32'h0);
        wait_idle();
        bus_read(0, d); check("R2 R3 cmd after frame", d, mk(0, 1, 2'b01, 5'd5, 5'h11, 16'hA5C3));
        bus_read(4, d); check("R8 write frame leaves read data", d, 32'h0201_0000);

        // R8: Clause 22 read
        resp = 16'h1234;
        bus_write(0, mk(1, 1, 2'b10, 5'd1, 5'd2, 16'h0));
        wait_idle();
        bus_read(4, d); check("R8 c22 read data", d, {16'h0201, 16'h1234});

        // R6 R9 R10: Clause 45 address then read, edge 1, delay 2
        bus_write(4, 32'h03A0_0000);
        bus_write(0, mk(1, 0, 2'b00, 5'd3, 5'd7, 16'h0100));
        wait_idle();
        resp = 16'hC0DE;
        bus_write(0, mk(1, 0, 2'b11, 5'd3, 5'd7, 16'h0));
        wait_idle();
        bus_read(4, d); check("R10 c45 read sampled at H+D", d[15:0], 32'hC0DE);

        // R9 R10 R11: half-period 0 acts as 1, delay 7 clamps to 2H-1
        bus_write(4, 32'h0070_0000);
        bus_read(4, d); check("R11 zero half-period stored", d[31:16], 32'h0071);
        resp = 16'hBEEF;
        bus_write(0, mk(1, 1, 2'b10, 5'd31, 5'd0, 16'h0));
        wait_idle();
        bus_read(4, d); check("R9 R10 clamped sample read", d[15:0], 32'hBEEF);

        // R5 R11: writes during a running frame
        bus_write(4, 32'h0210_0000);
        bus_write(0, mk(1, 1, 2'b01, 5'd9, 5'd3, 16'h5555));
        repeat (20) @(negedge clk);
        bus_write(0, mk(1, 0, 2'b11, 5'd31, 5'd31, 16'hFFFF));
        bus_write(4, 32'h0500_0000);
        bus_read(0, d); check("R5 busy write ignored", d, mk(1, 1, 2'b01, 5'd9, 5'd3, 16'h5555));
        wait_idle();
        bus_read(0, d); check("R5 fields kept after frame", d, mk(0, 1, 2'b01, 5'd9, 5'd3, 16'h5555));
        bus_read(4, d); check("R11 mid-frame setup visible", d[31:16], 32'h0501);

        // R4: store without launch
        bus_write(0, mk(0, 1, 2'b10, 5'd4, 5'd4, 16'h1111));
        repeat (40) @(negedge clk);
        bus_read(4, d); check("R4 no frame started", {31'd0, d[16]}, 32'h1);
        check("R4 MDC stays low", {31'd0, mdc_o}, 32'h0);
        bus_read(0, d); check("R4 fields stored", d, mk(0, 1, 2'b10, 5'd4, 5'd4, 16'h1111));

        // R12: quiet bus between frames
        check("R12 idle pins", {29'd0, mdc_o, mdio_oe, mdio_o}, 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule